// File: doc/BRIEF.md
# Dual-Channel UART Host Bus Front End

This block sits between an 8-bit asynchronous host bus and the register files of two independent UART channels. The host drives an active-low chip select, a channel-select line, a 3-bit register address, write data and active-low read and write strobes. The front end brings both strobes into the system clock domain and finds their edges. It then issues exactly one single-cycle register write or register read toward channel A or channel B. The register files and the serial engines live outside the block. The block returns their read data on a data bus that it drives only while a read is in progress.

Each channel has a small alternate function register inside this block. Bit 0 turns on broadcast writes: while it is set in either channel, one host write reaches both channels in the same cycle. Bits 2:1 pick what the channel's multi-function output carries. The alternate function register answers at address 2 while the register block raises the `alt_bank` input.

A bus state machine does the sequencing. Its states are IDLE, RD_LAUNCH, RD_HOLD, WR_HOLD and WR_COMMIT, and its transitions are:

| From | To | Condition |
|---|---|---|
| IDLE | RD_LAUNCH | synchronized read strobe falls while chip select is low |
| IDLE | WR_HOLD | synchronized write strobe falls while chip select is low |
| RD_LAUNCH | RD_HOLD | always, after one cycle |
| RD_HOLD | IDLE | synchronized read strobe is high |
| WR_HOLD | WR_COMMIT | synchronized write strobe is high |
| WR_COMMIT | IDLE | always, after one cycle |

If both strobes fall in the same cycle, IDLE takes the read.

Top module: `dual_uart_host_fe`

## Requirements
- R1: With chip select low, a host write with `ch_sel`=1 reaches only channel A (`reg_wr_a`), and one with `ch_sel`=0 reaches only channel B (`reg_wr_b`), while broadcast is off.
- R2: Each write strobe gives exactly one single-cycle write pulse. The pulse comes after the strobe's rising edge and carries the address and data that were present when the strobe ended.
- R3: While bit 0 of either channel's alternate function register is 1, a host write with chip select low pulses `reg_wr_a` and `reg_wr_b` in the same cycle, whatever the level of `ch_sel`.
- R4: After a falling edge of the read strobe, exactly one read pulse goes to the addressed channel. The block then drives `rdata_oe`=1 with that register's value until the strobe returns high. At all other times `rdata_oe` is 0 and `rdata` is 0.
- R5: Reads ignore broadcast. While broadcast is on, a read with `ch_sel`=1 pulses only `reg_rd_a` and returns channel A's data, and a read with `ch_sel`=0 pulses only `reg_rd_b` and returns channel B's data.
- R6: Strobes given while chip select is high have no effect. No register pulse is issued, `rdata_oe` stays 0, and the register contents stay unchanged.
- R7: With `alt_bank`=1 and address 2, a write loads bits 2:0 of the write data into the alternate function register of the target channel or channels, and issues no register write pulse. A read in the same setting returns that register in bits 2:0 with bits 7:3 at zero, and issues no register read pulse.
- R8: When alternate function bits 2:1 are 00, the channel's multi-function output is the inverse of that channel's modem control bit 3 input.
- R9: When bits 2:1 are 01 the output carries `baud16_x`. When they are 10 it carries `rxrdy_n_x`. When they are 11 it is held high.
- R10: Reset (active high) clears both alternate function registers and leaves no register pulse pending with `rdata_oe` at 0, so each multi-function output follows the inverse of its modem control bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Host chip select, active low |
| ch_sel | input | 1 | 1 selects channel A, 0 selects channel B |
| addr | input | ADDR_W | Host register address |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| wdata | input | DATA_W | Host write data |
| alt_bank | input | 1 | From the register block: address 2 maps to the alternate function register |
| rdata | output | DATA_W | Host read data, zero when not driven |
| rdata_oe | output | 1 | Data bus output enable |
| reg_wr_a | output | 1 | Register write pulse, channel A |
| reg_wr_b | output | 1 | Register write pulse, channel B |
| reg_rd_a | output | 1 | Register read pulse, channel A |
| reg_rd_b | output | 1 | Register read pulse, channel B |
| reg_addr | output | ADDR_W | Register address for both channels |
| reg_wdata | output | DATA_W | Register write data for both channels |
| reg_rdata_a | input | DATA_W | Addressed register value, channel A |
| reg_rdata_b | input | DATA_W | Addressed register value, channel B |
| mcr3_a | input | 1 | Modem control bit 3, channel A |
| mcr3_b | input | 1 | Modem control bit 3, channel B |
| baud16_a | input | 1 | 16x baud clock, channel A |
| baud16_b | input | 1 | 16x baud clock, channel B |
| rxrdy_n_a | input | 1 | Receive-ready DMA signal (active low), channel A |
| rxrdy_n_b | input | 1 | Receive-ready DMA signal (active low), channel B |
| mf_a | output | 1 | Multi-function output, channel A |
| mf_b | output | 1 | Multi-function output, channel B |

## Verification
The assertions check on every cycle that:
- the two read pulses are never high together;
- a dual write pulse happens only while a broadcast bit is set;
- write pulses last a single cycle;
- the data bus is never enabled in the same cycle as a register pulse;
- the reserved output mode holds the pin high.

The bench's scenarios cover the end-to-end results:
- data written over the host bus and read back from the correct channel;
- chip-select-high strobes that change nothing;
- alternate function register access with no pulses;
- each output mode.

The bench also compares both multi-function outputs with its model on every clock between transactions.

// File: rtl/fe_pkg.sv
package fe_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_LAUNCH,
        ST_RD_HOLD,
        ST_WR_HOLD,
        ST_WR_COMMIT
    } fe_state_t;

    typedef enum logic [1:0] {
        MF_OPOUT = 2'b00,
        MF_BAUD  = 2'b01,
        MF_RXRDY = 2'b10,
        MF_RSVD  = 2'b11
    } mf_sel_t;

    localparam int AFR_BITS = 3;
    localparam int NUM_CH   = 2;

endpackage

// File: rtl/fe_strobe_sync.sv
module fe_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_n,
    output logic level,
    output logic fall,
    output logic rise
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] sync_q;
    logic          prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q[0] <= strobe_n;
            for (int k = 1; k < STAGES; k++) begin
                sync_q[k] <= sync_q[k-1];
            end
            prev_q <= sync_q[LAST];
        end
    end

    assign level = sync_q[LAST];
    assign fall  = prev_q & ~sync_q[LAST];
    assign rise  = ~prev_q & sync_q[LAST];
endmodule

// File: rtl/fe_chan_afr.sv
module fe_chan_afr
    import fe_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [AFR_BITS-1:0] wdata,
    input  logic                mcr3,
    input  logic                baud16,
    input  logic                rxrdy_n,
    output logic [AFR_BITS-1:0] afr,
    output logic                mf
);
    logic [AFR_BITS-1:0] afr_q;
    mf_sel_t             sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            afr_q <= '0;
        end else if (we) begin
            afr_q <= wdata;
        end
    end

    assign sel = mf_sel_t'(afr_q[2:1]);
    assign afr = afr_q;

    always_comb begin
        unique case (sel)
            MF_OPOUT: mf = ~mcr3;
            MF_BAUD:  mf = baud16;
            MF_RXRDY: mf = rxrdy_n;
            MF_RSVD:  mf = 1'b1;
            default:  mf = 1'b1;
        endcase
    end
endmodule

// File: rtl/fe_bus_fsm.sv
module fe_bus_fsm
    import fe_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 8,
    parameter int AFR_ADDR = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rd_fall,
    input  logic                rd_level,
    input  logic                wr_fall,
    input  logic                wr_level,
    input  logic                cs_n,
    input  logic                ch_sel,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                alt_bank,
    input  logic                bcast,
    input  logic [DATA_W-1:0]   reg_rdata_a,
    input  logic [DATA_W-1:0]   reg_rdata_b,
    input  logic [AFR_BITS-1:0] afr_a,
    input  logic [AFR_BITS-1:0] afr_b,
    output logic                reg_wr_a,
    output logic                reg_wr_b,
    output logic                reg_rd_a,
    output logic                reg_rd_b,
    output logic [ADDR_W-1:0]   reg_addr,
    output logic [DATA_W-1:0]   reg_wdata,
    output logic                afr_we_a,
    output logic                afr_we_b,
    output logic [DATA_W-1:0]   rdata,
    output logic                rdata_oe
);
    localparam logic [ADDR_W-1:0] AFR_A = ADDR_W'(AFR_ADDR);
    localparam int PAD_W = DATA_W - AFR_BITS;

    fe_state_t state_q, state_d;

    logic [ADDR_W-1:0] txn_addr_q;
    logic [DATA_W-1:0] txn_data_q;
    logic              txn_ch_q;
    logic              txn_alt_q;
    logic              txn_cs_ok_q;
    logic [DATA_W-1:0] rdata_q;
    logic              afr_hit;
    logic              commit;
    logic              tgt_a;
    logic              tgt_b;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rd_fall && !cs_n)      state_d = ST_RD_LAUNCH;
                else if (wr_fall && !cs_n) state_d = ST_WR_HOLD;
            end
            ST_RD_LAUNCH: state_d = ST_RD_HOLD;
            ST_RD_HOLD:   if (rd_level) state_d = ST_IDLE;
            ST_WR_HOLD:   if (wr_level) state_d = ST_WR_COMMIT;
            ST_WR_COMMIT: state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // transaction capture
    always_ff @(posedge clk) begin
        if (rst) begin
            txn_addr_q  <= '0;
            txn_data_q  <= '0;
            txn_ch_q    <= 1'b0;
            txn_alt_q   <= 1'b0;
            txn_cs_ok_q <= 1'b0;
            rdata_q     <= '0;
        end else begin
            if ((state_q == ST_IDLE && state_d != ST_IDLE) || state_q == ST_WR_HOLD) begin
                txn_addr_q  <= addr;
                txn_data_q  <= wdata;
                txn_ch_q    <= ch_sel;
                txn_alt_q   <= alt_bank;
                txn_cs_ok_q <= !cs_n;
            end
            if (state_q == ST_RD_LAUNCH) begin
                if (afr_hit)
                    rdata_q <= {{PAD_W{1'b0}}, (txn_ch_q ? afr_a : afr_b)};
                else
                    rdata_q <= txn_ch_q ? reg_rdata_a : reg_rdata_b;
            end
        end
    end

    assign afr_hit = txn_alt_q && (txn_addr_q == AFR_A);
    assign commit  = (state_q == ST_WR_COMMIT) && txn_cs_ok_q;
    assign tgt_a   = bcast || txn_ch_q;
    assign tgt_b   = bcast || !txn_ch_q;

    // outputs
    always_comb begin
        reg_wr_a  = commit && tgt_a && !afr_hit;
        reg_wr_b  = commit && tgt_b && !afr_hit;
        afr_we_a  = commit && tgt_a && afr_hit;
        afr_we_b  = commit && tgt_b && afr_hit;
        reg_rd_a  = (state_q == ST_RD_LAUNCH) && !afr_hit && txn_ch_q;
        reg_rd_b  = (state_q == ST_RD_LAUNCH) && !afr_hit && !txn_ch_q;
        reg_addr  = txn_addr_q;
        reg_wdata = txn_data_q;
        rdata_oe  = (state_q == ST_RD_HOLD);
        rdata     = rdata_oe ? rdata_q : '0;
    end
endmodule

// File: rtl/dual_uart_host_fe.sv
module dual_uart_host_fe
    import fe_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int AFR_ADDR    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              ch_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] wdata,
    input  logic              alt_bank,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe,
    output logic              reg_wr_a,
    output logic              reg_wr_b,
    output logic              reg_rd_a,
    output logic              reg_rd_b,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata_a,
    input  logic [DATA_W-1:0] reg_rdata_b,
    input  logic              mcr3_a,
    input  logic              mcr3_b,
    input  logic              baud16_a,
    input  logic              baud16_b,
    input  logic              rxrdy_n_a,
    input  logic              rxrdy_n_b,
    output logic              mf_a,
    output logic              mf_b
);
    logic rd_level, rd_fall, rd_rise;
    logic wr_level, wr_fall, wr_rise;
    logic afr_we_a, afr_we_b;
    logic [AFR_BITS-1:0] afr_a, afr_b;

    logic [NUM_CH-1:0]   ch_we, ch_mcr3, ch_baud, ch_rxrdy, ch_mf;
    logic [AFR_BITS-1:0] ch_afr [NUM_CH];

    fe_strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
        .clk(clk), .rst(rst), .strobe_n(rd_n),
        .level(rd_level), .fall(rd_fall), .rise(rd_rise)
    );

    fe_strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
        .clk(clk), .rst(rst), .strobe_n(wr_n),
        .level(wr_level), .fall(wr_fall), .rise(wr_rise)
    );

    fe_bus_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .AFR_ADDR(AFR_ADDR)) u_fsm (
        .clk(clk), .rst(rst),
        .rd_fall(rd_fall), .rd_level(rd_level),
        .wr_fall(wr_fall), .wr_level(wr_level),
        .cs_n(cs_n), .ch_sel(ch_sel), .addr(addr), .wdata(wdata),
        .alt_bank(alt_bank), .bcast(afr_a[0] | afr_b[0]),
        .reg_rdata_a(reg_rdata_a), .reg_rdata_b(reg_rdata_b),
        .afr_a(afr_a), .afr_b(afr_b),
        .reg_wr_a(reg_wr_a), .reg_wr_b(reg_wr_b),
        .reg_rd_a(reg_rd_a), .reg_rd_b(reg_rd_b),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .afr_we_a(afr_we_a), .afr_we_b(afr_we_b),
        .rdata(rdata), .rdata_oe(rdata_oe)
    );

    // index 0 is channel A, index 1 is channel B
    assign ch_we    = {afr_we_b, afr_we_a};
    assign ch_mcr3  = {mcr3_b, mcr3_a};
    assign ch_baud  = {baud16_b, baud16_a};
    assign ch_rxrdy = {rxrdy_n_b, rxrdy_n_a};

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        fe_chan_afr u_afr (
            .clk(clk), .rst(rst),
            .we(ch_we[c]), .wdata(reg_wdata[AFR_BITS-1:0]),
            .mcr3(ch_mcr3[c]), .baud16(ch_baud[c]), .rxrdy_n(ch_rxrdy[c]),
            .afr(ch_afr[c]), .mf(ch_mf[c])
        );
    end

    assign afr_a = ch_afr[0];
    assign afr_b = ch_afr[1];
    assign mf_a  = ch_mf[0];
    assign mf_b  = ch_mf[1];

    logic unused_edges;
    assign unused_edges = rd_rise ^ wr_rise;
endmodule

// File: rtl/fe_checker.sv
module fe_checker #(
    parameter int AFR_BITS = 3
) (
    input logic                clk,
    input logic                rst,
    input logic                reg_wr_a,
    input logic                reg_wr_b,
    input logic                reg_rd_a,
    input logic                reg_rd_b,
    input logic                rdata_oe,
    input logic [AFR_BITS-1:0] afr_a,
    input logic [AFR_BITS-1:0] afr_b,
    input logic                mf_a,
    input logic                mf_b
);
    assert_rd_single_R5: assert property (@(posedge clk) disable iff (rst)
        !(reg_rd_a && reg_rd_b));

    assert_dual_wr_bcast_R3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_a && reg_wr_b) |-> (afr_a[0] || afr_b[0]));

    assert_wr_a_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        reg_wr_a |=> !reg_wr_a);

    assert_wr_b_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        reg_wr_b |=> !reg_wr_b);

    assert_oe_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        rdata_oe |-> !(reg_wr_a || reg_wr_b || reg_rd_a || reg_rd_b));

    assert_mf_rsvd_R9: assert property (@(posedge clk) disable iff (rst)
        ((afr_a[2:1] == 2'b11) |-> mf_a) and ((afr_b[2:1] == 2'b11) |-> mf_b));
endmodule

bind dual_uart_host_fe fe_checker #(.AFR_BITS(3)) i_fe_checker (
    .clk(clk), .rst(rst),
    .reg_wr_a(reg_wr_a), .reg_wr_b(reg_wr_b),
    .reg_rd_a(reg_rd_a), .reg_rd_b(reg_rd_b),
    .rdata_oe(rdata_oe),
    .afr_a(afr_a), .afr_b(afr_b),
    .mf_a(mf_a), .mf_b(mf_b)
);

// File: tb/test_dual_uart_host_fe.sv
module test_dual_uart_host_fe;
    logic       clk = 0;
    logic       rst = 1;
    logic       cs_n = 1, ch_sel = 1, rd_n = 1, wr_n = 1, alt_bank = 0;
    logic [2:0] addr = 0;
    logic [7:0] wdata = 0;
    logic [7:0] rdata;
    logic       rdata_oe, reg_wr_a, reg_wr_b, reg_rd_a, reg_rd_b;
    logic [2:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata_a, reg_rdata_b;
    logic       mcr3_a = 1, mcr3_b = 1, baud16_a = 0, baud16_b = 1;
    logic       rxrdy_n_a = 1, rxrdy_n_b = 0;
    logic       mf_a, mf_b;

    int errors = 0, checks = 0, cycles = 0;
    int n_wa = 0, n_wb = 0, n_ra = 0, n_rb = 0;
    bit mf_track = 0;

    logic [7:0] mem_a [8];
    logic [7:0] mem_b [8];
    logic [7:0] exp_a [8];
    logic [7:0] exp_b [8];
    logic [2:0] exp_afr_a = 0, exp_afr_b = 0;

    always #2.5 clk = ~clk;

    dual_uart_host_fe i_dual_uart_host_fe (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ch_sel(ch_sel), .addr(addr),
        .rd_n(rd_n), .wr_n(wr_n), .wdata(wdata), .alt_bank(alt_bank),
        .rdata(rdata), .rdata_oe(rdata_oe),
        .reg_wr_a(reg_wr_a), .reg_wr_b(reg_wr_b),
        .reg_rd_a(reg_rd_a), .reg_rd_b(reg_rd_b),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata_a(reg_rdata_a), .reg_rdata_b(reg_rdata_b),
        .mcr3_a(mcr3_a), .mcr3_b(mcr3_b),
        .baud16_a(baud16_a), .baud16_b(baud16_b),
        .rxrdy_n_a(rxrdy_n_a), .rxrdy_n_b(rxrdy_n_b),
        .mf_a(mf_a), .mf_b(mf_b)
    );

    assign reg_rdata_a = mem_a[reg_addr];
    assign reg_rdata_b = mem_b[reg_addr];

    task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    function automatic logic mf_model(logic [2:0] afr, logic mcr3, logic baud, logic rxr);
        case (afr[2:1])
            2'b00:   return ~mcr3;
            2'b01:   return baud;
            2'b10:   return rxr;
            default: return 1'b1;
        endcase
    endfunction

    // register file stand-in and pulse counters
    always @(posedge clk) begin
        if (!rst) begin
            if (reg_wr_a) begin mem_a[reg_addr] <= reg_wdata; n_wa++; end
            if (reg_wr_b) begin mem_b[reg_addr] <= reg_wdata; n_wb++; end
            if (reg_rd_a) n_ra++;
            if (reg_rd_b) n_rb++;
        end
    end

    always @(negedge clk) baud16_a <= ~baud16_a;

    // per-clock comparison of the output pins against the model (R8, R9)
    always begin
        @(posedge clk);
        #1;
        cycles++;
        if (!rst && mf_track) begin
            chk("R8/R9 mf_a per-clock", mf_a, mf_model(exp_afr_a, mcr3_a, baud16_a, rxrdy_n_a));
            chk("R8/R9 mf_b per-clock", mf_b, mf_model(exp_afr_b, mcr3_b, baud16_b, rxrdy_n_b));
        end
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below 100000", cycles);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic host_write(bit cs, bit ch, bit alt, logic [2:0] a, logic [7:0] d, string tag);
        bit bc, ta, tb, hit;
        mf_track = 0;
        @(negedge clk);
        n_wa = 0; n_wb = 0; n_ra = 0; n_rb = 0;
        cs_n = cs; ch_sel = ch; alt_bank = alt; addr = a; wdata = d; wr_n = 0;
        repeat (4) @(negedge clk);
        wr_n = 1;
        repeat (6) @(negedge clk);
        cs_n = 1;
        bc  = exp_afr_a[0] | exp_afr_b[0];
        hit = alt && (a == 3'd2);
        ta  = !cs && (bc || ch);
        tb  = !cs && (bc || !ch);
        if (hit) begin
            if (ta) exp_afr_a = d[2:0];
            if (tb) exp_afr_b = d[2:0];
        end else begin
            if (ta) exp_a[a] = d;
            if (tb) exp_b[a] = d;
        end
        chk({tag, " wr_a pulses"}, n_wa, (ta && !hit) ? 1 : 0);
        chk({tag, " wr_b pulses"}, n_wb, (tb && !hit) ? 1 : 0);
        chk({tag, " mem_a"}, mem_a[a], exp_a[a]);
        chk({tag, " mem_b"}, mem_b[a], exp_b[a]);
        mf_track = 1;
    endtask

    task automatic host_read(bit cs, bit ch, bit alt, logic [2:0] a, string tag);
        bit hit;
        logic [7:0] e;
        @(negedge clk);
        n_wa = 0; n_wb = 0; n_ra = 0; n_rb = 0;
        cs_n = cs; ch_sel = ch; alt_bank = alt; addr = a; rd_n = 0;
        repeat (6) @(negedge clk);
        hit = alt && (a == 3'd2);
        if (hit) e = {5'b0, (ch ? exp_afr_a : exp_afr_b)};
        else     e = ch ? exp_a[a] : exp_b[a];
        chk({tag, " oe during read"}, rdata_oe, !cs);
        chk({tag, " rdata"}, rdata, cs ? 8'h00 : e);
        chk({tag, " rd_a pulses"}, n_ra, (!cs && !hit && ch) ? 1 : 0);
        chk({tag, " rd_b pulses"}, n_rb, (!cs && !hit && !ch) ? 1 : 0);
        rd_n = 1;
        repeat (6) @(negedge clk);
        cs_n = 1;
        chk({tag, " oe released"}, rdata_oe, 0);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            mem_a[i] = 0; mem_b[i] = 0; exp_a[i] = 0; exp_b[i] = 0;
        end
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R10: reset state
        chk("R10 oe after reset", rdata_oe, 0);
        chk("R10 no pulses after reset", {reg_wr_a, reg_wr_b, reg_rd_a, reg_rd_b}, 0);
        chk("R10 mf_a follows OP", mf_a, 0);
        chk("R10 mf_b follows OP", mf_b, 0);
        mf_track = 1;

        // R1, R2: steered writes, read back (R4)
        host_write(0, 1, 0, 3'd3, 8'h5A, "R1 R2 write A");
        host_write(0, 0, 0, 3'd3, 8'hC3, "R1 R2 write B");
        host_write(0, 0, 0, 3'd7, 8'h81, "R1 write B addr7");
        host_read(0, 1, 0, 3'd3, "R4 read A");
        host_read(0, 0, 0, 3'd3, "R4 read B");
        host_read(0, 0, 0, 3'd7, "R4 read B addr7");

        // R6: deselected strobes ignored
        host_write(1, 1, 0, 3'd3, 8'hFF, "R6 write deselected");
        host_read(1, 1, 0, 3'd3, "R6 read deselected");
        host_read(0, 1, 0, 3'd3, "R6 A unchanged");

        // R7: alternate function register, enable broadcast on A
        host_write(0, 1, 1, 3'd2, 8'hF9, "R7 afr A write");
        host_read(0, 1, 1, 3'd2, "R7 afr A read");
        host_read(0, 0, 1, 3'd2, "R7 afr B read");
        host_write(0, 1, 0, 3'd2, 8'h12, "R7 addr2 normal reg");

        // R3: broadcast, both channel-select levels
        host_write(0, 1, 0, 3'd5, 8'h77, "R3 broadcast ch1");
        host_write(0, 0, 0, 3'd6, 8'h3C, "R3 broadcast ch0");
        // R5: reads during broadcast go to one channel
        host_read(0, 0, 0, 3'd3, "R5 read B bcast");
        host_read(0, 1, 0, 3'd3, "R5 read A bcast");

        // R8/R9: broadcast AFR write selects baud on both, turns broadcast off
        host_write(0, 1, 1, 3'd2, 8'h02, "R9 afr both baud");
        repeat (3) @(negedge clk);
        chk("R9 mf_a baud", mf_a, baud16_a);
        chk("R9 mf_b baud", mf_b, baud16_b);
        host_write(0, 0, 1, 3'd2, 8'h04, "R9 afr B rxrdy");
        host_write(0, 1, 1, 3'd2, 8'h06, "R9 afr A reserved");
        @(negedge clk);
        rxrdy_n_b = 1;
        @(negedge clk);
        chk("R9 mf_b rxrdy high", mf_b, 1);
        rxrdy_n_b = 0;
        @(negedge clk);
        chk("R9 mf_b rxrdy low", mf_b, 0);
        chk("R9 mf_a reserved", mf_a, 1);
        host_write(0, 1, 1, 3'd2, 8'h00, "R8 afr A op");
        mcr3_a = 0;
        @(negedge clk);
        chk("R8 mf_a op with mcr3 0", mf_a, 1);
        mcr3_a = 1;
        @(negedge clk);
        chk("R8 mf_a op with mcr3 1", mf_a, 0);

        // R10: reset clears the AFR
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        exp_afr_a = 0; exp_afr_b = 0;
        @(negedge clk);
        chk("R10 mf_b OP after reset", mf_b, 0);
        host_read(0, 0, 1, 3'd2, "R10 afr B cleared");

        repeat (5) @(negedge clk);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule